// File: doc/BRIEF.md
# Fast Privileged Return State Loader

This block is the execute-stage logic for the fast return from kernel privilege (level 0) to user privilege (level 3). A single-cycle request strobe captures the current processor mode, the current privilege level, the operand size, a LOCK-prefix flag, a 16-bit selector base register, and the RCX and RDX values. One cycle later the block reports one of two results. The first is a fault, either invalid-opcode or general-protection with error code zero. The second is a complete new user state: the stack pointer, the instruction pointer, the code and stack selectors, both descriptor caches and the new privilege level.

The block reads no descriptor tables. It computes both selectors from the base register, using offsets that depend on the operand size. It fills both descriptor caches with fixed flat user-segment constants. Every fault check is settled before any architectural output changes, so a faulting request leaves the architectural outputs exactly as they were.

Top module: `fast_ret_loader`

## Requirements
- R1: While `rst` is high and in the cycle after it, `done` is 0, `fault` is 0 (none), every architectural output is 0, and `new_cpl` is 0.
- R2: `done` is high for exactly the cycle after each cycle in which `req` is high, and low otherwise. Requests may arrive back to back.
- R3: A request with `lock_pfx` set reports `fault` = 1 (invalid opcode). This outranks every other fault.
- R4: The mode encoding is 0 real, 1 virtual-8086, 2 legacy protected, 3 compatibility, 4 64-bit, and values 5 to 7 act as 2. With no LOCK, mode 0 or 1 reports `fault` = 2 (general protection, error code 0).
- R5: With no LOCK and an allowed mode, `fault` = 2 is reported when `sel_base[15:2]` is all zero or when `cpl` is not 0.
- R6: In mode 4 only, and only when no earlier fault applies, `fault` = 2 is reported if the new stack pointer or the new instruction pointer is non-canonical. A value is canonical when bits 63:47 are all equal.
- R7: On success with `op64` = 1, `new_rsp` = RCX and `new_rip` = RDX. With `op64` = 0, both are the low 32 bits, zero-extended.
- R8: On success, `cs_sel` = (`sel_base` + 32 when `op64`, otherwise + 16) mod 2^16, then ORed with 3.
- R9: On success, `ss_sel` = `cs_sel` + 8 (mod 2^16).
- R10: The cache layout from MSB to LSB is base[62:31], limit[30:11], type[10:7], S[6], DPL[5:4], P[3], L[2], D/B[1], G[0]. On success, `cs_cache` holds base 0, limit FFFFF hex, type 11, S 1, DPL 3, P 1 and G 1. L is 1 and D/B is 0 when `op64` is set; otherwise L is 0 and D/B is 1.
- R11: On success, `ss_cache` holds base 0, limit FFFFF hex, type 3, S 1, DPL 3, P 1, L 0, D/B 1 and G 1.
- R12: On success, `new_cpl` becomes 3.
- R13: On a faulting request, `new_rsp`, `new_rip`, `cs_sel`, `ss_sel`, both caches and `new_cpl` keep their previous values. `fault` updates only on a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle request strobe |
| mode | input | 3 | Current processor mode |
| cpl | input | 2 | Current privilege level |
| op64 | input | 1 | 64-bit operand size |
| lock_pfx | input | 1 | LOCK prefix present |
| sel_base | input | 16 | Selector base register |
| rcx | input | 64 | Source for the new stack pointer |
| rdx | input | 64 | Source for the new instruction pointer |
| done | output | 1 | Result valid pulse |
| fault | output | 2 | 0 none, 1 invalid opcode, 2 general protection |
| new_rsp | output | 64 | New stack pointer |
| new_rip | output | 64 | New instruction pointer |
| cs_sel | output | 16 | New code selector |
| ss_sel | output | 16 | New stack selector |
| cs_cache | output | 63 | New code descriptor cache |
| ss_cache | output | 63 | New stack descriptor cache |
| new_cpl | output | 2 | New privilege level |

## Verification
Several fault conditions can be true in the same request, and the priority logic must then pick exactly one fault kind. The bench provokes this with stimuli that stack conditions together: LOCK with real mode, a zero selector index with a nonzero CPL in 64-bit mode, and a non-canonical RDX together with CPL 1. The bench also tests the case where a fault and a successful load arrive on consecutive cycles. It judges each result by the reported fault kind. It also checks that every architectural output still equals the value left by the last successful request, against a behavioural model compared on every clock.

// File: rtl/fret_pkg.sv
package fret_pkg;

    localparam int ADDR_W_DEF = 64;
    localparam int VA_W_DEF   = 48;
    localparam int SEL_W_DEF  = 16;

    typedef enum logic [2:0] {
        MODE_REAL   = 3'd0,
        MODE_V86    = 3'd1,
        MODE_PROT   = 3'd2,
        MODE_COMPAT = 3'd3,
        MODE_LONG   = 3'd4
    } cpu_mode_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_UD   = 2'd1,
        FLT_GP   = 2'd2
    } fault_e;

    typedef struct packed {
        logic [31:0] base;
        logic [19:0] limit;
        logic [3:0]  seg_type;
        logic        s;
        logic [1:0]  dpl;
        logic        p;
        logic        l;
        logic        db;
        logic        g;
    } seg_cache_t;

    localparam int CACHE_W = $bits(seg_cache_t);

    localparam logic [19:0] FLAT_LIMIT = 20'hFFFFF;
    localparam logic [3:0]  CODE_TYPE  = 4'd11;
    localparam logic [3:0]  STACK_TYPE = 4'd3;
    localparam logic [1:0]  USER_PL    = 2'd3;

endpackage

// File: rtl/fret_fault_check.sv
module fret_fault_check
    import fret_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int VA_W   = VA_W_DEF,
    parameter int SEL_W  = SEL_W_DEF
) (
    input  logic              lock_pfx,
    input  logic [2:0]        mode,
    input  logic [1:0]        cpl,
    input  logic [SEL_W-1:2]  sel_idx,
    input  logic [ADDR_W-1:0] rsp_cand,
    input  logic [ADDR_W-1:0] rip_cand,
    output fault_e            flt
);
    localparam int HI_W = ADDR_W - VA_W + 1;

    logic [HI_W-1:0] rsp_hi, rip_hi;
    logic            rsp_canon, rip_canon;
    logic            mode_bad, sel_bad, canon_bad;

    assign rsp_hi    = rsp_cand[ADDR_W-1:VA_W-1];
    assign rip_hi    = rip_cand[ADDR_W-1:VA_W-1];
    assign rsp_canon = (&rsp_hi) | ~(|rsp_hi);
    assign rip_canon = (&rip_hi) | ~(|rip_hi);

    assign mode_bad  = (mode == MODE_REAL) || (mode == MODE_V86);
    assign sel_bad   = ~(|sel_idx) || (cpl != 2'd0);
    assign canon_bad = (mode == MODE_LONG) && !(rsp_canon && rip_canon);

    always_comb begin
        if (lock_pfx)       flt = FLT_UD;
        else if (mode_bad)  flt = FLT_GP;
        else if (sel_bad)   flt = FLT_GP;
        else if (canon_bad) flt = FLT_GP;
        else                flt = FLT_NONE;
    end
endmodule

// File: rtl/fret_ptr_sel.sv
module fret_ptr_sel
    import fret_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              op64,
    input  logic [ADDR_W-1:0] rcx,
    input  logic [ADDR_W-1:0] rdx,
    output logic [ADDR_W-1:0] rsp_nxt,
    output logic [ADDR_W-1:0] rip_nxt
);
    localparam int LOW_W = 32;

    always_comb begin
        if (op64) begin
            rsp_nxt = rcx;
            rip_nxt = rdx;
        end else begin
            rsp_nxt = {{(ADDR_W-LOW_W){1'b0}}, rcx[LOW_W-1:0]};
            rip_nxt = {{(ADDR_W-LOW_W){1'b0}}, rdx[LOW_W-1:0]};
        end
    end
endmodule

// File: rtl/fret_sel_gen.sv
module fret_sel_gen
    import fret_pkg::*;
#(
    parameter int SEL_W    = SEL_W_DEF,
    parameter int CS_OFF64 = 32,
    parameter int CS_OFF32 = 16,
    parameter int SS_STEP  = 8
) (
    input  logic             op64,
    input  logic [SEL_W-1:0] sel_base,
    output logic [SEL_W-1:0] cs_nxt,
    output logic [SEL_W-1:0] ss_nxt
);
    localparam logic [SEL_W-1:0] OFF64 = SEL_W'(CS_OFF64);
    localparam logic [SEL_W-1:0] OFF32 = SEL_W'(CS_OFF32);
    localparam logic [SEL_W-1:0] STEP  = SEL_W'(SS_STEP);
    localparam logic [SEL_W-1:0] RPL3  = SEL_W'(3);

    logic [SEL_W-1:0] cs_sum;

    assign cs_sum = sel_base + (op64 ? OFF64 : OFF32);
    assign cs_nxt = cs_sum | RPL3;
    assign ss_nxt = cs_nxt + STEP;
endmodule

// File: rtl/fret_cache_gen.sv
module fret_cache_gen
    import fret_pkg::*;
(
    input  logic       op64,
    output seg_cache_t cs_nxt,
    output seg_cache_t ss_nxt
);
    seg_cache_t seg [2];

    for (genvar gi = 0; gi < 2; gi++) begin : g_seg
        if (gi == 0) begin : g_code
            always_comb begin
                seg[gi]          = '0;
                seg[gi].limit    = FLAT_LIMIT;
                seg[gi].seg_type = CODE_TYPE;
                seg[gi].s        = 1'b1;
                seg[gi].dpl      = USER_PL;
                seg[gi].p        = 1'b1;
                seg[gi].l        = op64;
                seg[gi].db       = ~op64;
                seg[gi].g        = 1'b1;
            end
        end else begin : g_stack
            always_comb begin
                seg[gi]          = '0;
                seg[gi].limit    = FLAT_LIMIT;
                seg[gi].seg_type = STACK_TYPE;
                seg[gi].s        = 1'b1;
                seg[gi].dpl      = USER_PL;
                seg[gi].p        = 1'b1;
                seg[gi].db       = 1'b1;
                seg[gi].g        = 1'b1;
            end
        end
    end

    assign cs_nxt = seg[0];
    assign ss_nxt = seg[1];
endmodule

// File: rtl/fast_ret_loader.sv
module fast_ret_loader
    import fret_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int VA_W   = VA_W_DEF,
    parameter int SEL_W  = SEL_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic [2:0]         mode,
    input  logic [1:0]         cpl,
    input  logic               op64,
    input  logic               lock_pfx,
    input  logic [SEL_W-1:0]   sel_base,
    input  logic [ADDR_W-1:0]  rcx,
    input  logic [ADDR_W-1:0]  rdx,
    output logic               done,
    output logic [1:0]         fault,
    output logic [ADDR_W-1:0]  new_rsp,
    output logic [ADDR_W-1:0]  new_rip,
    output logic [SEL_W-1:0]   cs_sel,
    output logic [SEL_W-1:0]   ss_sel,
    output logic [CACHE_W-1:0] cs_cache,
    output logic [CACHE_W-1:0] ss_cache,
    output logic [1:0]         new_cpl
);
    fault_e            flt_w, flt_q;
    logic [ADDR_W-1:0] rsp_w, rip_w;
    logic [SEL_W-1:0]  cs_w, ss_w;
    seg_cache_t        csc_w, ssc_w;

    logic              done_q;
    logic [ADDR_W-1:0] rsp_q, rip_q;
    logic [SEL_W-1:0]  cs_q, ss_q;
    seg_cache_t        csc_q, ssc_q;
    logic [1:0]        cpl_q;

    fret_ptr_sel #(.ADDR_W(ADDR_W)) u_ptr (
        .op64    (op64),
        .rcx     (rcx),
        .rdx     (rdx),
        .rsp_nxt (rsp_w),
        .rip_nxt (rip_w)
    );

    fret_fault_check #(.ADDR_W(ADDR_W), .VA_W(VA_W), .SEL_W(SEL_W)) u_flt (
        .lock_pfx (lock_pfx),
        .mode     (mode),
        .cpl      (cpl),
        .sel_idx  (sel_base[SEL_W-1:2]),
        .rsp_cand (rsp_w),
        .rip_cand (rip_w),
        .flt      (flt_w)
    );

    fret_sel_gen #(.SEL_W(SEL_W)) u_sel (
        .op64     (op64),
        .sel_base (sel_base),
        .cs_nxt   (cs_w),
        .ss_nxt   (ss_w)
    );

    fret_cache_gen u_cache (
        .op64   (op64),
        .cs_nxt (csc_w),
        .ss_nxt (ssc_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            flt_q  <= FLT_NONE;
            rsp_q  <= '0;
            rip_q  <= '0;
            cs_q   <= '0;
            ss_q   <= '0;
            csc_q  <= '0;
            ssc_q  <= '0;
            cpl_q  <= 2'd0;
        end else begin
            done_q <= req;
            if (req) begin
                flt_q <= flt_w;
                if (flt_w == FLT_NONE) begin
                    rsp_q <= rsp_w;
                    rip_q <= rip_w;
                    cs_q  <= cs_w;
                    ss_q  <= ss_w;
                    csc_q <= csc_w;
                    ssc_q <= ssc_w;
                    cpl_q <= USER_PL;
                end
            end
        end
    end

    assign done     = done_q;
    assign fault    = flt_q;
    assign new_rsp  = rsp_q;
    assign new_rip  = rip_q;
    assign cs_sel   = cs_q;
    assign ss_sel   = ss_q;
    assign cs_cache = csc_q;
    assign ss_cache = ssc_q;
    assign new_cpl  = cpl_q;
endmodule

// File: rtl/fret_chk.sv
module fret_chk #(
    parameter int ADDR_W = 64,
    parameter int SEL_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              lock_pfx,
    input logic [2:0]        mode,
    input logic              op64,
    input logic              done,
    input logic [1:0]        fault,
    input logic [ADDR_W-1:0] new_rsp,
    input logic [ADDR_W-1:0] new_rip,
    input logic [SEL_W-1:0]  cs_sel,
    input logic [SEL_W-1:0]  ss_sel,
    input logic [1:0]        new_cpl
);
    // R2
    done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> done);

    // R2
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> !done);

    // R3
    lock_ud_chk: assert property (@(posedge clk) disable iff (rst)
        (req && lock_pfx) |=> (fault == 2'd1));

    // R4
    mode_gp_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !lock_pfx && (mode < 3'd2)) |=> (fault == 2'd2));

    // R7
    zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !op64) |=> (fault != 2'd0 || (new_rsp[ADDR_W-1:32] == '0 && new_rip[ADDR_W-1:32] == '0)));

    // R8
    cs_rpl_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault == 2'd0) |-> (cs_sel[1:0] == 2'b11));

    // R9
    ss_step_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault == 2'd0) |-> (ss_sel == cs_sel + SEL_W'(8)));

    // R12
    user_cpl_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault == 2'd0) |-> (new_cpl == 2'd3));

    // R13
    hold_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault != 2'd0) |-> ($stable(new_rsp) && $stable(new_rip) &&
                                     $stable(cs_sel) && $stable(ss_sel) && $stable(new_cpl)));

    // R13
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(fault));
endmodule

bind fast_ret_loader fret_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_fret_chk (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .lock_pfx (lock_pfx),
    .mode     (mode),
    .op64     (op64),
    .done     (done),
    .fault    (fault),
    .new_rsp  (new_rsp),
    .new_rip  (new_rip),
    .cs_sel   (cs_sel),
    .ss_sel   (ss_sel),
    .new_cpl  (new_cpl)
);

// File: tb/test_fast_ret_loader.sv
module test_fast_ret_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [1:0]  cpl = 2'd0;
    logic        op64 = 1'b0;
    logic        lock_pfx = 1'b0;
    logic [15:0] sel_base = 16'd0;
    logic [63:0] rcx = 64'd0;
    logic [63:0] rdx = 64'd0;
    logic        done;
    logic [1:0]  fault;
    logic [63:0] new_rsp, new_rip;
    logic [15:0] cs_sel, ss_sel;
    logic [62:0] cs_cache, ss_cache;
    logic [1:0]  new_cpl;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fast_ret_loader i_fast_ret_loader (
        .clk(clk), .rst(rst), .req(req), .mode(mode), .cpl(cpl), .op64(op64),
        .lock_pfx(lock_pfx), .sel_base(sel_base), .rcx(rcx), .rdx(rdx),
        .done(done), .fault(fault), .new_rsp(new_rsp), .new_rip(new_rip),
        .cs_sel(cs_sel), .ss_sel(ss_sel), .cs_cache(cs_cache), .ss_cache(ss_cache),
        .new_cpl(new_cpl)
    );

    // Behavioural reference state
    logic        m_done;
    logic [1:0]  m_fault;
    logic [63:0] m_rsp, m_rip;
    logic [15:0] m_cs, m_ss;
    logic [62:0] m_csc, m_ssc;
    logic [1:0]  m_cpl;

    function automatic bit canon(input logic [63:0] v);
        logic [63:0] top;
        top = v >> 47;
        return (top == 64'd0) || (top == 64'h1FFFF);
    endfunction

    function automatic logic [1:0] ref_fault(input logic lk, input logic [2:0] md,
            input logic [1:0] cp, input logic [15:0] sb,
            input logic [63:0] sp, input logic [63:0] ip);
        if (lk) return 2'd1;
        if (md == 3'd0 || md == 3'd1) return 2'd2;
        if ((sb >> 2) == 16'd0 || cp != 2'd0) return 2'd2;
        if (md == 3'd4 && !(canon(sp) && canon(ip))) return 2'd2;
        return 2'd0;
    endfunction

    always @(posedge clk) begin
        logic [63:0] sp, ip;
        logic [15:0] cs;
        logic [1:0]  f;
        if (rst) begin
            m_done <= 0; m_fault <= 0; m_rsp <= 0; m_rip <= 0; m_cs <= 0;
            m_ss <= 0; m_csc <= 0; m_ssc <= 0; m_cpl <= 0;
        end else begin
            m_done <= req;
            if (req) begin
                sp = op64 ? rcx : (rcx & 64'hFFFF_FFFF);
                ip = op64 ? rdx : (rdx & 64'hFFFF_FFFF);
                f  = ref_fault(lock_pfx, mode, cpl, sel_base, sp, ip);
                m_fault <= f;
                if (f == 2'd0) begin
                    cs = sel_base + (op64 ? 16'd32 : 16'd16);
                    cs = cs | 16'd3;
                    m_rsp <= sp;
                    m_rip <= ip;
                    m_cs  <= cs;
                    m_ss  <= cs + 16'd8;
                    m_csc <= {32'd0, 20'hFFFFF, 4'd11, 1'b1, 2'd3, 1'b1, op64, ~op64, 1'b1};
                    m_ssc <= {32'd0, 20'hFFFFF, 4'd3, 1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1};
                    m_cpl <= 2'd3;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R2 done",              64'(done),     64'(m_done));
            chk("R3 R4 R5 R6 fault",    64'(fault),    64'(m_fault));
            chk("R7 new_rsp",           new_rsp,       m_rsp);
            chk("R7 new_rip",           new_rip,       m_rip);
            chk("R8 cs_sel",            64'(cs_sel),   64'(m_cs));
            chk("R9 ss_sel",            64'(ss_sel),   64'(m_ss));
            chk("R10 cs_cache",         64'(cs_cache), 64'(m_csc));
            chk("R11 ss_cache",         64'(ss_cache), 64'(m_ssc));
            chk("R12 new_cpl",          64'(new_cpl),  64'(m_cpl));
        end
    end

    task automatic issue(input logic lk, input logic [2:0] md, input logic [1:0] cp,
            input logic op, input logic [15:0] sb, input logic [63:0] c, input logic [63:0] d);
        req = 1'b1; lock_pfx = lk; mode = md; cpl = cp; op64 = op;
        sel_base = sb; rcx = c; rdx = d;
        @(negedge clk);
    endtask

    task automatic idle();
        req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] keep_rsp;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1 done in reset",  64'(done),  64'd0);
        chk("R1 fault in reset", 64'(fault), 64'd0);
        chk("R1 rsp in reset",   new_rsp,    64'd0);
        chk("R1 cpl in reset",   64'(new_cpl), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cs_cache after reset", 64'(cs_cache), 64'd0);
        chk("R1 ss_sel after reset",   64'(ss_sel),   64'd0);

        // R7 R8 R10: 64-bit success
        issue(0, 3'd4, 0, 1, 16'h0040, 64'h0000_7FFF_FFFF_F000, 64'hFFFF_8000_0000_1000);
        idle();
        chk("R12 cpl after success", 64'(new_cpl), 64'd3);
        // R7: 32-bit zero extension in compatibility mode
        issue(0, 3'd3, 0, 0, 16'h0080, 64'hDEAD_BEEF_1234_5678, 64'h8000_0000_9ABC_DEF0);
        idle();
        chk("R7 zero-extended rsp", new_rsp, 64'h0000_0000_1234_5678);
        // legacy protected, out-of-range mode value acts as protected
        issue(0, 3'd2, 0, 0, 16'h0104, 64'h1111, 64'h2222);
        issue(0, 3'd6, 0, 1, 16'h0204, 64'h3333, 64'h4444);
        idle();
        keep_rsp = new_rsp;
        // R3: LOCK outranks real mode
        issue(1, 3'd0, 2, 1, 16'h0000, 64'h5, 64'h6);
        idle();
        chk("R3 lock over mode", 64'(fault), 64'd1);
        chk("R13 rsp held", new_rsp, keep_rsp);
        // R4
        issue(0, 3'd0, 0, 0, 16'h0100, 64'h7, 64'h8);
        issue(0, 3'd1, 0, 0, 16'h0100, 64'h7, 64'h8);
        idle();
        // R5: selector index boundary and CPL
        issue(0, 3'd4, 0, 1, 16'h0003, 64'h10, 64'h20);
        issue(0, 3'd4, 0, 1, 16'h0004, 64'h10, 64'h20);
        issue(0, 3'd4, 1, 1, 16'h0100, 64'h30, 64'h40);
        issue(0, 3'd4, 3, 0, 16'h0000, 64'h30, 64'h40);
        idle();
        chk("R5 cpl fault", 64'(fault), 64'd2);
        // R6: canonical boundaries
        issue(0, 3'd4, 0, 1, 16'h0100, 64'h0000_8000_0000_0000, 64'h50);
        idle();
        chk("R6 non-canonical rsp", 64'(fault), 64'd2);
        issue(0, 3'd4, 0, 1, 16'h0100, 64'h60, 64'hFFFF_7FFF_FFFF_FFFF);
        issue(0, 3'd4, 0, 1, 16'h0100, 64'hFFFF_8000_0000_0000, 64'h0000_7FFF_FFFF_FFFF);
        issue(0, 3'd3, 0, 1, 16'h0100, 64'h0000_8000_0000_0000, 64'h70);
        issue(0, 3'd4, 1, 1, 16'h0100, 64'h80, 64'h1234_0000_0000_0000);
        idle();
        // R8 R9: selector wrap
        issue(0, 3'd4, 0, 1, 16'hFFF8, 64'h90, 64'hA0);
        idle();
        chk("R8 wrapped cs_sel", 64'(cs_sel), 64'h001B);
        chk("R9 wrapped ss_sel", 64'(ss_sel), 64'h0023);
        issue(0, 3'd2, 0, 0, 16'hFFF0, 64'h90, 64'hA0);
        issue(1, 3'd4, 0, 1, 16'h0100, 64'hB0, 64'hC0);
        idle();
        chk("R13 cs_sel held", 64'(cs_sel), 64'h0003);
        repeat (3) idle();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule